// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

This block manages four shared pins that serve two roles one after the other. While the system is coming out of reset, each pin is an input that carries a board-level configuration strap. The pin driver is held off (high impedance) during this phase. After a programmable settling count of reference-clock cycles, every pin is sampled on several consecutive cycles, and a per-pin majority vote decides the value that is latched. The latched value then stays frozen until the next reset. In the same cycle the output drivers are enabled, and each pin carries its clock. Pin 0 and pin 1 hold the two host-swing multiplier selects. Pin 2 and pin 3 hold the two frequency-mode selects.

A pin that nothing on the board drives is pulled up weakly, so it must read as 1. The sequencer has four named states:
- `ST_HOLD` counts the settling interval. It moves to `ST_SAMPLE` when the count is done.
- `ST_SAMPLE` collects `SAMPLE_COUNT` votes per pin. It moves to `ST_LATCH` after the last vote.
- `ST_LATCH` commits the majority results. It moves to `ST_RUN` unconditionally.
- `ST_RUN` enables the drivers and raises the ready flag. It is left only through reset.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While `rst_n` is low, `pin_oe_o` and `pin_out_o` are all 0, `ready_o` is 0 and `strap_o` reads all ones.
- R2: Counting rising edges from reset release, `ready_o` and `pin_oe_o` stay 0 through edge `SETTLE_CYCLES + SAMPLE_COUNT`. They become 1 right after edge `SETTLE_CYCLES + SAMPLE_COUNT + 1`.
- R3: Each strap is sampled on edges `SETTLE_CYCLES+1` through `SETTLE_CYCLES+SAMPLE_COUNT`. Bit k of `strap_o` is 1 exactly when more than half of the samples of pin k were 1.
- R4: A pin whose `pin_ext_drive_i` bit is 0 (not driven on the board) is sampled as 1, whatever `pin_in_i` shows.
- R5: `ready_o` and every bit of `pin_oe_o` rise in the same cycle, and the enable bits never differ from one another.
- R6: Once `ready_o` is 1, it stays 1 and `strap_o` stays unchanged until reset. Pin values present on the latch edge, or any later edge, have no effect.
- R7: `pin_out_o[k]` follows `clk_src_i[k]` while `pin_oe_o[k]` is 1, and is 0 while it is 0.
- R8: A reset in any state, including `ST_SAMPLE` and `ST_RUN`, restarts the whole sequence. The straps are then sampled afresh.
- R9: Field layout: `strap_o[1:0]` hold the host-swing multiplier selects taken from pins 0 and 1. `strap_o[3:2]` hold the frequency-mode selects taken from pins 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, start of power-up |
| pin_in_i | input | NUM_STRAPS | Level seen on each shared pin |
| pin_ext_drive_i | input | NUM_STRAPS | 1 when the board drives the pin, 0 when only the pull-up acts |
| clk_src_i | input | NUM_STRAPS | Clock to send out on each pin once enabled |
| pin_out_o | output | NUM_STRAPS | Output value towards each pin driver |
| pin_oe_o | output | NUM_STRAPS | Output enable of each pin driver |
| strap_o | output | NUM_STRAPS | Latched strap values |
| ready_o | output | 1 | Straps latched and clocks running |

## Verification
Two events fall into the same cycle: the vote bank commits its majority, and the pins change on that very edge as the sequencer turns them into outputs. The bench provokes this with fully driven pin values that are the complement of the expected result. It applies them right after the last sampling edge, so they are present on the latch edge. It then judges that `strap_o` matches the vote over the sampling window alone. Random strap patterns and the 3-of-5 and 2-of-5 vote boundaries are compared with a bench function that applies the pull-up rule and the majority rule.

// File: rtl/strap_cap_pkg.sv
package strap_cap_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_LATCH  = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;

    // strap field layout (R9)
    localparam int SWING_LSB = 0;
    localparam int SWING_W   = 2;
    localparam int MODE_LSB  = 2;
    localparam int MODE_W    = 2;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/strap_seq_fsm.sv
module strap_seq_fsm
    import strap_cap_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000,
    parameter int SAMPLE_COUNT  = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_en_o,
    output logic latch_en_o,
    output logic drive_en_o
);

    localparam int CNT_MAX = max2(SETTLE_CYCLES, SAMPLE_COUNT);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_COUNT - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                if (cnt_q == SETTLE_LAST) begin
                    state_d = ST_SAMPLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == SAMPLE_LAST) begin
                    state_d = ST_LATCH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LATCH: begin
                state_d = ST_RUN;
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        sample_en_o = 1'b0;
        latch_en_o  = 1'b0;
        drive_en_o  = 1'b0;
        unique case (state_q)
            ST_HOLD:   ;
            ST_SAMPLE: sample_en_o = 1'b1;
            ST_LATCH:  latch_en_o  = 1'b1;
            ST_RUN:    drive_en_o  = 1'b1;
            default:   ;
        endcase
    end

    // R2
    hold_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q <= SETTLE_LAST));

    // R2
    run_entry_from_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($past(state_q) == ST_LATCH || $past(state_q) == ST_RUN));

    // R6
    run_is_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

endmodule

// File: rtl/strap_vote_bank.sv
module strap_vote_bank #(
    parameter int NUM_PINS     = 4,
    parameter int SAMPLE_COUNT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl_i,
    input  logic                sample_en_i,
    input  logic                latch_en_i,
    output logic [NUM_PINS-1:0] strap_o
);

    localparam int VOTE_W = $clog2(SAMPLE_COUNT + 1);

    logic [NUM_PINS-1:0] strap_q;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_vote
        logic [VOTE_W-1:0] votes_q;
        logic              majority;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                votes_q <= '0;
            end else if (sample_en_i && pin_lvl_i[k]) begin
                votes_q <= votes_q + 1'b1;
            end
        end

        assign majority = ((32'(votes_q) * 2) > SAMPLE_COUNT);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                strap_q[k] <= 1'b1;
            end else if (latch_en_i) begin
                strap_q[k] <= majority;
            end
        end

        // R3
        vote_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(votes_q) <= SAMPLE_COUNT);
    end

    assign strap_o = strap_q;

    // R6
    strap_change_only_on_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strap_q) |-> $past(latch_en_i));

endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl #(
    parameter int NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0] pin_in_i,
    input  logic [NUM_PINS-1:0] pin_ext_drive_i,
    input  logic [NUM_PINS-1:0] clk_src_i,
    input  logic                drive_en_i,
    output logic [NUM_PINS-1:0] pin_lvl_o,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o
);

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pad
        // weak pull-up wins when nothing drives the pin
        assign pin_lvl_o[k] = pin_ext_drive_i[k] ? pin_in_i[k] : 1'b1;
        assign pin_oe_o[k]  = drive_en_i;
        assign pin_out_o[k] = drive_en_i & clk_src_i[k];
    end

endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
    import strap_cap_pkg::*;
#(
    parameter int NUM_STRAPS    = 4,
    parameter int SETTLE_CYCLES = 1000,
    parameter int SAMPLE_COUNT  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STRAPS-1:0] pin_in_i,
    input  logic [NUM_STRAPS-1:0] pin_ext_drive_i,
    input  logic [NUM_STRAPS-1:0] clk_src_i,
    output logic [NUM_STRAPS-1:0] pin_out_o,
    output logic [NUM_STRAPS-1:0] pin_oe_o,
    output logic [NUM_STRAPS-1:0] strap_o,
    output logic                  ready_o
);

    localparam int READY_EDGE = SETTLE_CYCLES + SAMPLE_COUNT + 1;
    localparam int AGE_W      = $clog2(READY_EDGE + 2);

    logic                  sample_en, latch_en, drive_en;
    logic [NUM_STRAPS-1:0] pin_lvl;

    strap_seq_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .SAMPLE_COUNT  (SAMPLE_COUNT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_o (sample_en),
        .latch_en_o  (latch_en),
        .drive_en_o  (drive_en)
    );

    strap_pad_ctrl #(
        .NUM_PINS (NUM_STRAPS)
    ) u_pad (
        .pin_in_i        (pin_in_i),
        .pin_ext_drive_i (pin_ext_drive_i),
        .clk_src_i       (clk_src_i),
        .drive_en_i      (drive_en),
        .pin_lvl_o       (pin_lvl),
        .pin_out_o       (pin_out_o),
        .pin_oe_o        (pin_oe_o)
    );

    strap_vote_bank #(
        .NUM_PINS     (NUM_STRAPS),
        .SAMPLE_COUNT (SAMPLE_COUNT)
    ) u_vote (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_lvl_i   (pin_lvl),
        .sample_en_i (sample_en),
        .latch_en_i  (latch_en),
        .strap_o     (strap_o)
    );

    assign ready_o = drive_en;

    // edges since reset release, saturating (checker state)
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (32'(age_q) < READY_EDGE) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R2
    ready_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (32'(age_q) >= READY_EDGE));

    // R5
    oe_ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o == {NUM_STRAPS{ready_o}});

    // R6
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> (ready_o && $stable(strap_o)));

    // R7
    out_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (pin_out_o == '0));

endmodule

// File: tb/test_strap_capture_ctrl.sv
module test_strap_capture_ctrl;

    localparam int N  = 4;
    localparam int S  = 20;
    localparam int SC = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0, pin_drv = '0, clk_src = '0;
    logic [N-1:0] pin_out, pin_oe, strap;
    logic         ready;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [N-1:0] pat_in [SC];
    logic [N-1:0] pat_dr [SC];

    always #10 clk = ~clk;

    strap_capture_ctrl #(
        .NUM_STRAPS(N), .SETTLE_CYCLES(S), .SAMPLE_COUNT(SC)
    ) i_strap_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in_i(pin_in), .pin_ext_drive_i(pin_drv),
        .clk_src_i(clk_src), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
        .strap_o(strap), .ready_o(ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pull-up rule (R4) then majority rule (R3)
    function automatic logic [N-1:0] expect_straps();
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) begin
            int ones = 0;
            for (int s = 0; s < SC; s++)
                if (!pat_dr[s][k] || pat_in[s][k]) ones++;
            r[k] = (2 * ones > SC);
        end
        return r;
    endfunction

    task automatic junk();
        pin_in  = N'($urandom);
        pin_drv = N'($urandom);
        clk_src = N'($urandom);
    endtask

    task automatic run_seq(input string label);
        logic [N-1:0] exp_s;
        exp_s = expect_straps();
        rst_n = 1'b0;
        clk_src = '1;
        repeat (3) @(negedge clk);
        // R1 (also R8 when a previous sequence ran)
        chk(pin_oe == '0 && ready == 1'b0, "R1 oe/ready in reset", {pin_oe, 3'b0, ready}, 0);
        chk(pin_out == '0, "R1 out in reset", pin_out, 0);
        chk(strap == '1, "R1 R8 strap reset value", strap, 4'hF);
        rst_n = 1'b1;
        junk();
        for (int i = 1; i <= S; i++) begin
            @(negedge clk);
            if (i == 1 || i == S) begin
                chk(ready == 0 && pin_oe == '0 && pin_out == '0, "R2 hold phase", {pin_oe, 3'b0, ready}, 0);
            end
            if (i < S) junk();
            else begin pin_in = pat_in[0]; pin_drv = pat_dr[0]; clk_src = N'($urandom); end
        end
        for (int j = 0; j < SC; j++) begin
            @(negedge clk);
            if (j == SC - 1)
                chk(ready == 0 && pin_oe == '0, "R2 last edge before ready", {pin_oe, 3'b0, ready}, 0);
            if (j < SC - 1) begin
                pin_in = pat_in[j+1]; pin_drv = pat_dr[j+1];
            end else begin
                // values on the latch edge must be ignored (R6)
                pin_in = ~exp_s; pin_drv = '1;
            end
        end
        @(negedge clk);
        chk(ready == 1'b1 && pin_oe == '1, "R5 ready with enables", {pin_oe, 3'b0, ready}, 32'hF1);
        chk(strap == exp_s, {"R3 R4 R6 latched value ", label}, strap, exp_s);
        chk(strap[1:0] == exp_s[1:0] && strap[3:2] == exp_s[3:2], "R9 field layout", strap, exp_s);
        for (int c = 0; c < 6; c++) begin
            junk();
            @(negedge clk);
            chk(pin_out == clk_src, "R7 clock passthrough", pin_out, clk_src);
            chk(strap == exp_s && ready, "R6 straps frozen", {strap, 3'b0, ready}, {exp_s, 4'h1});
        end
    endtask

    task automatic set_all(input logic [N-1:0] v_in, input logic [N-1:0] v_dr);
        for (int s = 0; s < SC; s++) begin pat_in[s] = v_in; pat_dr[s] = v_dr; end
    endtask

    initial begin
        void'($urandom(32'd7781));
        // all undriven: pull-ups give 1111 (R4)
        set_all(4'h0, 4'h0);
        run_seq("undriven");
        // all driven low (R8 re-sampling after RUN)
        set_all(4'h0, 4'hF);
        run_seq("driven low");
        chk(strap == 4'h0, "R8 new sequence resampled", strap, 0);
        // vote boundary: pin0 one in 3 of 5 -> 1, pin1 2 of 5 -> 0,
        // pin2 4 of 5 -> 1, pin3 undriven in 2, low in 3 -> 0
        pat_in[0] = 4'b0111; pat_dr[0] = 4'b0111;
        pat_in[1] = 4'b0111; pat_dr[1] = 4'b0111;
        pat_in[2] = 4'b0101; pat_dr[2] = 4'b1111;
        pat_in[3] = 4'b0100; pat_dr[3] = 4'b1111;
        pat_in[4] = 4'b0000; pat_dr[4] = 4'b1111;
        run_seq("vote boundary");
        chk(strap == 4'b0101, "R3 boundary votes", strap, 4'b0101);
        // reset in the middle of sampling (R8)
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        pin_in = '0; pin_drv = '1;
        repeat (S + 2) @(negedge clk);
        chk(ready == 0, "R8 still sampling", ready, 0);
        set_all(4'h0, 4'h0);
        run_seq("after mid reset");
        // random patterns
        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < SC; s++) begin
                pat_in[s] = N'($urandom);
                pat_dr[s] = N'($urandom);
            end
            run_seq("random");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule